// File: doc/BRIEF.md
# Iambic Paddle Keyer

This block turns the two contacts of a Morse paddle into a timed key-down signal. The clock-enable `tick` runs at twice the dot-element rate. Two ticks make one timing unit. A dot is one unit of key-down followed by one unit of silence. A dash is three units of key-down followed by one unit of silence. The paddle levels arrive already debounced. Speed is set wholly by how often `tick` is pulsed.

While the keyer is idle, its unit divider is held cleared and the ticks have no effect. A lever seen in idle starts an element on the next clock edge. At the end of every trailing space the levers are sampled again:
- With only one lever held, that lever's element repeats.
- With both levers held, an alternation flop picks the element opposite to the last one.
- With neither lever held, the keyer goes back to idle.

An element always runs through its key-down time and its trailing space, even if the levers are released early. The key level drives the sidetone gate directly. A one-cycle strobe marks the start of each element so that a message recorder can follow the key.

Top module: `keyer`

## Requirements
- R1: During and straight after reset, `key_out`, `tone_gate`, `busy` and `elem_strobe` are all 0.
- R2: While idle with both levers released, pulses on `tick` leave `key_out` and `busy` at 0.
- R3: A dot holds `key_out` at 1 for exactly 2 ticks, then at 0 for 2 ticks of trailing space.
- R4: A dash holds `key_out` at 1 for exactly 6 ticks, then at 0 for 2 ticks of trailing space.
- R5: With only one lever held at the end of a trailing space, the next element is that lever's element (dot lever gives a dot, dash lever gives a dash).
- R6: When both levers are held at the end of a trailing space, the next element is the opposite of the previous one. When both are pressed together from idle, the first element is a dot.
- R7: Once started, an element and its trailing space run to completion whatever the levers do.
- R8: `busy` is 1 from the start of an element until the end of the trailing space after which no lever is held, and `key_out` is never 1 while `busy` is 0.
- R9: `tone_gate` equals `key_out` in every cycle.
- R10: `elem_strobe` is a one-cycle pulse in exactly the cycles where `key_out` rises at the start of an element.
- R11: A lever level present at a clock edge while idle makes `key_out`, `busy` and `elem_strobe` 1 right after that edge. Ticks seen in that idle cycle do not count toward the element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Clock enable at twice the dot-element rate |
| dot_lever | input | 1 | Debounced dot lever level, 1 = pressed |
| dash_lever | input | 1 | Debounced dash lever level, 1 = pressed |
| key_out | output | 1 | Key-down level, 1 = carrier on |
| tone_gate | output | 1 | Sidetone enable, follows key_out |
| busy | output | 1 | 1 while an element or its trailing space is in progress |
| elem_strobe | output | 1 | One-cycle pulse at the start of each element |

## Verification
A unit divider that has drifted shows up as a key-down time that is off by whole ticks, at the first element after the fault. A wrong alternation flop shows up as a repeated dot or dash while both levers are held, at the very next element boundary. A sequencer stuck out of idle shows up as `busy` staying high once the last trailing space should have closed, within two ticks. The bench runs a tick-accurate model built from the requirements and compares all four outputs in every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/keyer_pkg.sv
// Shared types for the paddle keyer.
// Assumes: none; a type-only package.
package keyer_pkg;
    typedef enum logic [1:0] {KS_IDLE, KS_MARK, KS_SPACE} kstate_t;
    typedef enum logic {EL_DOT = 1'b0, EL_DASH = 1'b1} elem_t;
endpackage

// File: rtl/keyer_unit_div.sv
// Divides the half-unit tick down to one strobe per timing unit.
// Assumes: TICKS_PER_UNIT >= 2; while run is low the count is held at zero,
// so every element starts on a fresh unit boundary.
module keyer_unit_div #(
    parameter int TICKS_PER_UNIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic unit_end
);
    localparam int CW = $clog2(TICKS_PER_UNIT);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_UNIT - 1);

    logic [CW-1:0] tcnt;

    // Unit boundary: last tick of the current unit while running.
    always_comb unit_end = run && tick && (tcnt == LAST);

    // Tick counter, cleared while idle and wrapped at each unit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt <= '0;
        end else if (tick) begin
            tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/keyer_elem_sel.sv
// Picks the next element from the lever levels and holds the alternation flop.
// Assumes: the levers are debounced and synchronous to clk; load pulses on the
// edge where a new element begins, and fresh is high only while idle.
module keyer_elem_sel
    import keyer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dot_lever,
    input  logic  dash_lever,
    input  logic  fresh,
    input  logic  load,
    output logic  next_valid,
    output elem_t next_elem,
    output elem_t cur_elem
);
    logic both;

    // Choice of the next element: alternate when both levers are held.
    always_comb begin
        both       = dot_lever && dash_lever;
        next_valid = dot_lever || dash_lever;
        if (both) begin
            next_elem = fresh ? EL_DOT : ((cur_elem == EL_DOT) ? EL_DASH : EL_DOT);
        end else if (dash_lever) begin
            next_elem = EL_DASH;
        end else begin
            next_elem = EL_DOT;
        end
    end

    // Alternation flop: remembers the element now being sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_elem <= EL_DOT;
        end else if (load) begin
            cur_elem <= next_elem;
        end
    end
endmodule

// File: rtl/keyer_seq.sv
// Mark/space sequencer: counts units for the key-down time and trailing space,
// and decides at the end of each space whether to start another element.
// Assumes: unit_end pulses once per unit while run is high; cur_elem is
// updated on the same edge as load.
module keyer_seq
    import keyer_pkg::*;
#(
    parameter int DOT_UNITS  = 1,
    parameter int DASH_UNITS = 3,
    parameter int GAP_UNITS  = 1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  unit_end,
    input  logic  next_valid,
    input  elem_t cur_elem,
    output logic  run,
    output logic  fresh,
    output logic  load,
    output logic  key,
    output logic  strobe
);
    localparam int MAXU = (DASH_UNITS > GAP_UNITS) ?
                          ((DASH_UNITS > DOT_UNITS) ? DASH_UNITS : DOT_UNITS) :
                          ((GAP_UNITS > DOT_UNITS) ? GAP_UNITS : DOT_UNITS);
    localparam int UCW = $clog2(MAXU + 1);
    localparam logic [UCW-1:0] DOT_LAST  = UCW'(DOT_UNITS - 1);
    localparam logic [UCW-1:0] DASH_LAST = UCW'(DASH_UNITS - 1);
    localparam logic [UCW-1:0] GAP_LAST  = UCW'(GAP_UNITS - 1);

    kstate_t        state;
    logic [UCW-1:0] ucnt;
    logic [UCW-1:0] mark_last;
    logic           mark_done;
    logic           space_done;
    logic           strobe_q;

    // Decode of the current phase and its end conditions.
    always_comb begin
        mark_last  = (cur_elem == EL_DASH) ? DASH_LAST : DOT_LAST;
        mark_done  = (state == KS_MARK)  && unit_end && (ucnt == mark_last);
        space_done = (state == KS_SPACE) && unit_end && (ucnt == GAP_LAST);
        fresh      = (state == KS_IDLE);
        run        = (state != KS_IDLE);
        load       = (fresh && next_valid) || (space_done && next_valid);
        key        = (state == KS_MARK);
        strobe     = strobe_q;
    end

    // State and unit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_IDLE;
            ucnt  <= '0;
        end else begin
            case (state)
                KS_IDLE: begin
                    ucnt <= '0;
                    if (next_valid) state <= KS_MARK;
                end
                KS_MARK: begin
                    if (mark_done) begin
                        state <= KS_SPACE;
                        ucnt  <= '0;
                    end else if (unit_end) begin
                        ucnt <= ucnt + 1'b1;
                    end
                end
                KS_SPACE: begin
                    if (space_done) begin
                        state <= next_valid ? KS_MARK : KS_IDLE;
                        ucnt  <= '0;
                    end else if (unit_end) begin
                        ucnt <= ucnt + 1'b1;
                    end
                end
                default: begin
                    state <= KS_IDLE;
                    ucnt  <= '0;
                end
            endcase
        end
    end

    // Element-start strobe, registered together with the key rise.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= load;
    end
endmodule

// File: rtl/keyer.sv
// Iambic paddle keyer top: unit divider, element selector and sequencer.
// Assumes: tick is a one-cycle enable at twice the dot rate; levers are
// debounced and synchronous; reset is synchronous and active low.
module keyer
    import keyer_pkg::*;
#(
    parameter int TICKS_PER_UNIT = 2,
    parameter int DOT_UNITS      = 1,
    parameter int DASH_UNITS     = 3,
    parameter int GAP_UNITS      = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic dot_lever,
    input  logic dash_lever,
    output logic key_out,
    output logic tone_gate,
    output logic busy,
    output logic elem_strobe
);
    logic  run;
    logic  unit_end;
    logic  fresh;
    logic  load;
    logic  next_valid;
    elem_t next_elem;
    elem_t cur_elem;
    logic  key;
    logic  strobe;

    keyer_unit_div #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .unit_end(unit_end)
    );

    keyer_elem_sel u_sel (
        .clk(clk), .rst_n(rst_n), .dot_lever(dot_lever), .dash_lever(dash_lever),
        .fresh(fresh), .load(load), .next_valid(next_valid),
        .next_elem(next_elem), .cur_elem(cur_elem)
    );

    keyer_seq #(
        .DOT_UNITS(DOT_UNITS), .DASH_UNITS(DASH_UNITS), .GAP_UNITS(GAP_UNITS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .unit_end(unit_end), .next_valid(next_valid),
        .cur_elem(cur_elem), .run(run), .fresh(fresh), .load(load),
        .key(key), .strobe(strobe)
    );

    // Output drive: one key level feeds both the key and the sidetone gate.
    always_comb begin
        key_out     = key;
        tone_gate   = key;
        busy        = run;
        elem_strobe = strobe;
    end
endmodule

// File: rtl/keyer_checker.sv
// Port-level properties of the keyer, bound to every keyer instance.
// Assumes: synchronous active-low reset.
module keyer_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic dot_lever,
    input logic dash_lever,
    input logic key_out,
    input logic tone_gate,
    input logic busy,
    input logic elem_strobe
);
    a_r9_tone_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
        tone_gate == key_out);

    a_r10_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_out) |-> elem_strobe);

    a_r10_strobe_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        elem_strobe |-> key_out);

    a_r8_key_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
        key_out |-> busy);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dot_lever && !dash_lever) |=> !busy);

    a_r11_start_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (dot_lever || dash_lever)) |=> (busy && key_out && elem_strobe));

    a_r7_no_change_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(key_out)));
endmodule

bind keyer keyer_checker u_keyer_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dot_lever(dot_lever),
    .dash_lever(dash_lever), .key_out(key_out), .tone_gate(tone_gate),
    .busy(busy), .elem_strobe(elem_strobe)
);

// File: tb/keyer_bench.sv
// Self-checking bench: tick-accurate model of the requirements, directed
// phases plus seeded random lever and tick patterns.
module keyer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic dot_lever = 1'b0;
    logic dash_lever = 1'b0;
    logic key_out, tone_gate, busy, elem_strobe;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;
    string tag = "R1";

    // Model state: 0 idle, 1 mark, 2 space; rem counts ticks left.
    int m_st = 0;
    int m_rem = 0;
    bit m_last = 1'b0;
    bit m_key = 1'b0;
    bit m_strobe = 1'b0;

    always #2 clk = ~clk;

    keyer u_keyer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dot_lever(dot_lever),
        .dash_lever(dash_lever), .key_out(key_out), .tone_gate(tone_gate),
        .busy(busy), .elem_strobe(elem_strobe)
    );

    function automatic int mark_ticks(bit is_dash);
        return is_dash ? 6 : 2;   // R3 dot 1 unit, R4 dash 3 units, 2 ticks/unit
    endfunction

    function automatic bit pick_next(bit dt, bit da, bit from_idle, bit last);
        if (dt && da) return from_idle ? 1'b0 : !last;   // R6
        return da;                                       // R5
    endfunction

    // Reference model, advanced at each rising edge from the stable inputs.
    always @(posedge clk) begin
        m_strobe = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_last = 1'b0; m_key = 1'b0;
        end else begin
            case (m_st)
                0: if (dot_lever || dash_lever) begin
                    m_last = pick_next(dot_lever, dash_lever, 1'b1, m_last);
                    m_st = 1; m_rem = mark_ticks(m_last); m_key = 1'b1; m_strobe = 1'b1;
                end
                1: if (tick) begin
                    m_rem--;
                    if (m_rem == 0) begin m_st = 2; m_rem = 2; m_key = 1'b0; end
                end
                default: if (tick) begin
                    m_rem--;
                    if (m_rem == 0) begin
                        if (dot_lever || dash_lever) begin
                            m_last = pick_next(dot_lever, dash_lever, 1'b0, m_last);
                            m_st = 1; m_rem = mark_ticks(m_last); m_key = 1'b1; m_strobe = 1'b1;
                        end else begin
                            m_st = 0;
                        end
                    end
                end
            endcase
        end
    end

    task automatic check(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // One cycle: compare outputs at the falling edge, then drive new inputs.
    task automatic step(bit dt, bit da, bit tk);
        @(negedge clk);
        check(tag, key_out, m_key);
        check("R9 tone_gate", tone_gate, m_key);
        check("R8 busy", busy, m_st != 0);
        check("R10 elem_strobe", elem_strobe, m_strobe);
        dot_lever = dt; dash_lever = da; tick = tk;
    endtask

    task automatic idle_out(int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        tag = "R1";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
        @(negedge clk);
        rst_n = 1'b1; dot_lever = 1'b0; dash_lever = 1'b0; tick = 1'b0;
        tag = "R1"; step(1'b0, 1'b0, 1'b0);
        tag = "R2"; idle_out(20);
        tag = "R3"; step(1'b1, 1'b0, 1'b0); idle_out(12);
        tag = "R4"; step(1'b0, 1'b1, 1'b1); idle_out(16);
        tag = "R5";
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, 1'b1);
        idle_out(8);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1);
        idle_out(12);
        tag = "R6";
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b1);
        idle_out(12);
        tag = "R7"; step(1'b0, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) step(1'b0, 1'b0, (i % 2) == 0);
        idle_out(6);
        tag = "R11";
        step(1'b1, 1'b0, 1'b1); step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b1, (i % 3) == 0);
        idle_out(16);
        tag = "R5 R6 random";
        begin
            bit dt = 1'b0, da = 1'b0;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(0, 7) == 0) dt = !dt;
                if ($urandom_range(0, 7) == 0) da = !da;
                step(dt, da, $urandom_range(0, 2) == 0);
            end
        end
        tag = "R8"; idle_out(20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule